// File: doc/BRIEF.md
# Pipeline Stage Hotspot Profiler

This unit watches a row of per-stage busy signals from a rendering pipeline and reports which stage was the bottleneck most often. Time is cut into measurement intervals whose length in clock cycles is programmable. Within each interval every stage accumulates a private tally of the cycles in which it was busy. When the interval closes, the single stage with the largest tally gains one point in its 16-bit result counter, and all tallies restart from zero.

Software sets the interval length and the number of intervals through a configuration word. It then starts a run by writing the enable bit. The eight counters are read back as four 32-bit words through one result port, and that port steps an internal word pointer on every read. A finite run stops by itself and raises a done flag. A run programmed with zero intervals keeps going until the result port is first read. In such a long run, the counters restart from zero each time the number of completed intervals rolls over its 16-bit range.

Top module: `hotspot_profiler`

## Requirements
- R1: After reset the control word reads 0 (bit 0 = running, bit 1 = done), `meas_done` is low and every result word reads 0.
- R2: A write to byte offset 0x0 with bit 0 set starts a run. It zeroes all eight counters, clears done and returns the result word pointer to word 0.
- R3: The configuration word at offset 0x4 holds the interval count in bits 15:0 and the interval length minus one in bits 31:16. Each interval lasts the length field plus one cycles, and it credits exactly one stage.
- R4: At the end of an interval, the credited stage is the one with the most busy cycles in that interval. A tie goes to the lowest stage index, and an interval in which no stage was busy credits stage 0.
- R5: When the length field is 0 or 1, every interval credits stage 0, whatever the busy inputs do.
- R6: With a non-zero count, the run ends on the interval that brings the completed total to the count. Done (control bit 1 and `meas_done`) then goes high and the running bit clears. The counters keep their values until the next start.
- R7: Reads of offset 0x8 return result word 0, 1, 2, 3 and then wrap to word 0. Word k holds stage 2k in bits 15:0 and stage 2k+1 in bits 31:16. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R8: With a count of 0, the run continues until the first read of the result port. That read returns the current counts, ends the run and sets done.
- R9: In an unbounded run, the interval that carries the completed total past 0xFFFF clears all counters to 0. Counting then continues from zero.
- R10: A read of the result port during a finite run returns the partial counts, and the run continues.
- R11: A write of 0 to bit 0 of the control word halts a run without setting done. The counters then hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| stage_busy | input | 8 | One busy flag per pipeline stage |
| meas_done | output | 1 | High once a run has ended by count or by read |

## Verification
The bench builds the block with its default parameters: eight stages, 16-bit counters and a 16-bit length field. Setting the length field to 0 gives one-cycle intervals, so a count-zero run can pass 65,536 intervals in about as many clocks and reach the roll-over clear of R9 in full. Longer intervals of 4 to 10 cycles, driven with constant, toggling and tied busy patterns, exercise the tally comparison of R4. They also let the bench place the done edge of a finite run on an exact clock.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int HSP_STAGES  = 8;
    localparam int HSP_CNT_W   = 16;
    localparam int HSP_ADDR_W  = 4;
    localparam int HSP_SHORT   = 2;   // length fields below this force stage 0

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_RES  = 2'd2,
        SEL_NONE = 2'd3
    } hsp_sel_e;

    typedef struct packed {
        logic [HSP_CNT_W-1:0] len_m1;
        logic [HSP_CNT_W-1:0] count;
    } hsp_cfg_t;

    function automatic hsp_sel_e hsp_decode(input logic [HSP_ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return SEL_NONE;
        case (a[3:2])
            2'd0:    return SEL_CTRL;
            2'd1:    return SEL_CFG;
            2'd2:    return SEL_RES;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hsp_tally.sv
module hsp_tally #(
    parameter int NSTAGE  = 8,
    parameter int TALLY_W = 17,
    localparam int IDX_W  = $clog2(NSTAGE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clr,
    input  logic [NSTAGE-1:0] busy,
    output logic [IDX_W-1:0]  win_idx
);
    logic [TALLY_W-1:0] tally [NSTAGE];
    logic [TALLY_W-1:0] nxt   [NSTAGE];

    // tallies including the current cycle, so the last cycle of an interval counts
    always_comb begin
        logic [TALLY_W-1:0] best;
        for (int i = 0; i < NSTAGE; i++)
            nxt[i] = tally[i] + TALLY_W'(busy[i]);
        best    = nxt[0];
        win_idx = '0;
        for (int i = 1; i < NSTAGE; i++) begin
            if (nxt[i] > best) begin
                best    = nxt[i];
                win_idx = IDX_W'(i);
            end
        end
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_tally
        always_ff @(posedge clk) begin
            if (rst || clr)
                tally[g] <= '0;
            else if (run)
                tally[g] <= nxt[g];
        end
    end

endmodule

// File: rtl/hsp_bank.sv
module hsp_bank #(
    parameter int NSTAGE = 8,
    parameter int CNT_W  = 16,
    localparam int IDX_W  = $clog2(NSTAGE),
    localparam int NWORD  = NSTAGE / 2,
    localparam int PTR_W  = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    inc,
    input  logic [IDX_W-1:0]        inc_idx,
    input  logic [PTR_W-1:0]        sel,
    output logic [2*CNT_W-1:0]      word,
    output logic [NSTAGE*CNT_W-1:0] flat
);
    logic [CNT_W-1:0]   cnt   [NSTAGE];
    logic [2*CNT_W-1:0] words [NWORD];

    for (genvar g = 0; g < NSTAGE; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr)
                cnt[g] <= '0;
            else if (inc && inc_idx == IDX_W'(g))
                cnt[g] <= cnt[g] + 1'b1;
        end
        assign flat[g*CNT_W +: CNT_W] = cnt[g];
    end

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign words[w] = {cnt[2*w+1], cnt[2*w]};
    end

    assign word = words[sel];

endmodule

// File: rtl/hotspot_profiler.sv
module hotspot_profiler
    import hsp_pkg::*;
#(
    parameter int NSTAGE = HSP_STAGES,
    parameter int CNT_W  = HSP_CNT_W,
    parameter int ADDR_W = HSP_ADDR_W,
    localparam int DATA_W = 2 * CNT_W,
    localparam int IDX_W  = $clog2(NSTAGE),
    localparam int NWORD  = NSTAGE / 2,
    localparam int PTR_W  = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSTAGE-1:0] stage_busy,
    output logic              meas_done
);
    hsp_sel_e           sel;
    hsp_cfg_t           cfg;
    logic               enable, done;
    logic [CNT_W-1:0]   cyc, total;
    logic [PTR_W-1:0]   ptr;
    logic               start, halt, res_rd, zero_stop, iv_end, last_iv, wrap;
    logic [IDX_W-1:0]   win_idx, credit_idx;
    logic [DATA_W-1:0]  res_word;
    logic [NSTAGE*CNT_W-1:0] cnt_flat;

    assign sel       = hsp_decode(HSP_ADDR_W'(bus_addr));
    assign start     = bus_wr && sel == SEL_CTRL &&  bus_wdata[0];
    assign halt      = bus_wr && sel == SEL_CTRL && !bus_wdata[0];
    assign res_rd    = bus_rd && sel == SEL_RES;
    assign zero_stop = enable && cfg.count == '0 && res_rd;
    assign iv_end    = enable && !start && !halt && !zero_stop && (cyc >= cfg.len_m1);
    assign last_iv   = iv_end && cfg.count != '0 && total == cfg.count - 1'b1;
    assign wrap      = iv_end && total == '1;
    assign credit_idx = (cfg.len_m1 < CNT_W'(HSP_SHORT)) ? '0 : win_idx;

    hsp_tally #(.NSTAGE(NSTAGE), .TALLY_W(CNT_W + 1)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .run     (enable),
        .clr     (start || iv_end),
        .busy    (stage_busy),
        .win_idx (win_idx)
    );

    hsp_bank #(.NSTAGE(NSTAGE), .CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr     (start || wrap),
        .inc     (iv_end && !wrap),
        .inc_idx (credit_idx),
        .sel     (ptr),
        .word    (res_word),
        .flat    (cnt_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            enable <= 1'b0;
            done   <= 1'b0;
            cyc    <= '0;
            total  <= '0;
            ptr    <= '0;
        end else begin
            if (bus_wr && sel == SEL_CFG)
                cfg <= hsp_cfg_t'(bus_wdata);

            if (start) begin
                enable <= 1'b1;
                done   <= 1'b0;
                cyc    <= '0;
                total  <= '0;
            end else if (halt) begin
                enable <= 1'b0;
            end else if (zero_stop || last_iv) begin
                enable <= 1'b0;
                done   <= 1'b1;
                total  <= total + 1'b1;
            end else if (iv_end) begin
                cyc    <= '0;
                total  <= total + 1'b1;
            end else if (enable) begin
                cyc    <= cyc + 1'b1;
            end

            if (start)
                ptr <= '0;
            else if (res_rd)
                ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_CTRL: bus_rdata <= {{(DATA_W-2){1'b0}}, done, enable};
                SEL_CFG:  bus_rdata <= DATA_W'(cfg);
                SEL_RES:  bus_rdata <= res_word;
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assign meas_done = done;

endmodule

// File: rtl/hsp_chk.sv
module hsp_chk #(
    parameter int NSTAGE = 8,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 3,
    parameter int PTR_W  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    enable,
    input logic                    done,
    input logic                    start,
    input logic                    iv_end,
    input logic                    last_iv,
    input logic [IDX_W-1:0]        credit_idx,
    input logic [CNT_W-1:0]        len_m1,
    input logic [CNT_W-1:0]        total,
    input logic [PTR_W-1:0]        ptr,
    input logic [NSTAGE*CNT_W-1:0] cnt_flat
);
    // R6
    run_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(enable && done));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_flat == '0 && ptr == '0 && total == '0 && enable && !done));

    // R3
    interval_step_chk: assert property (@(posedge clk) disable iff (rst)
        iv_end |=> total == $past(total) + 1'b1);

    // R5
    short_credit_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_end && len_m1 < 2) |-> credit_idx == '0);

    // R6
    finite_stop_chk: assert property (@(posedge clk) disable iff (rst)
        last_iv |=> (done && !enable));

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && !start) |=> $stable(cnt_flat));
endmodule

bind hotspot_profiler hsp_chk #(
    .NSTAGE(NSTAGE), .CNT_W(CNT_W), .IDX_W(IDX_W), .PTR_W(PTR_W)
) u_hsp_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .done       (done),
    .start      (start),
    .iv_end     (iv_end),
    .last_iv    (last_iv),
    .credit_idx (credit_idx),
    .len_m1     (cfg.len_m1),
    .total      (total),
    .ptr        (ptr),
    .cnt_flat   (cnt_flat)
);

// File: tb/tb_hotspot_profiler.sv
module tb_hotspot_profiler;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  base_busy = '0;
    logic        tog_en = 1'b0, tog = 1'b0;
    logic [7:0]  stage_busy;
    logic        meas_done;
    int          total_chk = 0, bad_chk = 0;
    logic [31:0] v, v2;

    assign stage_busy = base_busy | ((tog_en && tog) ? 8'h04 : 8'h00);

    always #5 clk = ~clk;
    always @(negedge clk) tog <= ~tog;

    hotspot_profiler dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stage_busy(stage_busy), .meas_done(meas_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !meas_done; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check(meas_done == 1'b0, "R1 done", 32'(meas_done), 0);
        rd_reg(4'h0, v); check(v == 0, "R1 ctrl", v, 0);
        rd_reg(4'h8, v); check(v == 0, "R1 word0", v, 0);
    endtask

    task automatic t_timing();
        base_busy = 8'h40;
        wr_reg(4'h4, {16'd4, 16'd2});
        wr_reg(4'h0, 32'h1);
        repeat (9) @(negedge clk);
        check(meas_done == 1'b0, "R3 done before tenth cycle", 32'(meas_done), 0);
        @(negedge clk);
        check(meas_done == 1'b1, "R3 done after two 5-cycle intervals", 32'(meas_done), 1);
        rd_reg(4'h0, v); check(v == 32'h2, "R6 ctrl done not running", v, 32'h2);
        rd_reg(4'h8, v); check(v == 0, "R7 word0", v, 0);
        rd_reg(4'h8, v); check(v == 0, "R7 word1", v, 0);
        rd_reg(4'h8, v); check(v == 0, "R7 word2", v, 0);
        rd_reg(4'h8, v); check(v == 32'h0000_0002, "R7 word3 stage6 low half", v, 32'h2);
        rd_reg(4'h8, v); check(v == 0, "R7 wrap to word0", v, 0);
        repeat (20) @(negedge clk);
        rd_reg(4'h8, v); rd_reg(4'h8, v); rd_reg(4'h8, v);
        check(v == 32'h2, "R6 counters frozen", v, 32'h2);
        rd_reg(4'h8, v);
        base_busy = 8'h00;
    endtask

    task automatic t_winner();
        base_busy = 8'h10; tog_en = 1'b1;
        wr_reg(4'h4, {16'd7, 16'd4});
        wr_reg(4'h0, 32'h1);
        wait_done();
        rd_reg(4'h8, v); rd_reg(4'h8, v);
        check(v == 0, "R4 toggling stage2 loses", v, 0);
        rd_reg(4'h8, v);
        check(v == 32'h4, "R4 stage4 most busy", v, 32'h4);
        tog_en = 1'b0;
        base_busy = 8'h28;
        wr_reg(4'h4, {16'd5, 16'd3});
        wr_reg(4'h0, 32'h1);
        wait_done();
        rd_reg(4'h8, v); rd_reg(4'h8, v);
        check(v == 32'h0003_0000, "R4 tie goes to stage3", v, 32'h0003_0000);
        rd_reg(4'h8, v);
        check(v == 0, "R4 stage5 not credited", v, 0);
        base_busy = 8'h00;
        wr_reg(4'h4, {16'd3, 16'd2});
        wr_reg(4'h0, 32'h1);
        wait_done();
        rd_reg(4'h8, v);
        check(v == 32'h2, "R4 idle credits stage0", v, 32'h2);
    endtask

    task automatic t_short();
        base_busy = 8'h20;
        wr_reg(4'h4, {16'd1, 16'd3});
        wr_reg(4'h0, 32'h1);
        wait_done();
        rd_reg(4'h8, v);
        check(v == 32'h3, "R5 short interval stage0", v, 32'h3);
        rd_reg(4'h8, v); rd_reg(4'h8, v);
        check(v == 0, "R5 stage5 ignored", v, 0);
        wr_reg(4'h0, 32'h1);
        wait_done();
        rd_reg(4'h8, v);
        check(v == 32'h3, "R2 restart clears and rewinds pointer", v, 32'h3);
        base_busy = 8'h00;
    endtask

    task automatic t_partial();
        base_busy = 8'h04;
        wr_reg(4'h4, {16'd9, 16'd100});
        wr_reg(4'h0, 32'h1);
        rd_reg(4'h8, v);
        repeat (30) @(negedge clk);
        rd_reg(4'h8, v);
        check(v == 32'h3, "R10 partial count", v, 32'h3);
        rd_reg(4'h0, v);
        check(v == 32'h1, "R10 still running", v, 32'h1);
        wait_done();
        rd_reg(4'h8, v); rd_reg(4'h8, v); rd_reg(4'h8, v); rd_reg(4'h8, v);
        check(v == 32'd100, "R3 sum equals count", v, 32'd100);
        base_busy = 8'h00;
    endtask

    task automatic t_zero();
        base_busy = 8'h80;
        wr_reg(4'h4, {16'd3, 16'd0});
        wr_reg(4'h0, 32'h1);
        repeat (40) @(negedge clk);
        check(meas_done == 1'b0, "R8 runs before read", 32'(meas_done), 0);
        rd_reg(4'h8, v);
        check(v == 0, "R8 word0", v, 0);
        rd_reg(4'h0, v);
        check(v == 32'h2, "R8 read ends run", v, 32'h2);
        rd_reg(4'h8, v); rd_reg(4'h8, v); rd_reg(4'h8, v);
        check(v[15:0] == 0 && v[31:16] != 0, "R8 stage7 counted", v, 32'h0);
        repeat (10) @(negedge clk);
        rd_reg(4'h8, v2); rd_reg(4'h8, v2); rd_reg(4'h8, v2); rd_reg(4'h8, v2);
        check(v2 == v, "R8 frozen after read", v2, v);
        base_busy = 8'h00;
    endtask

    task automatic t_overflow();
        base_busy = 8'h01;
        wr_reg(4'h4, {16'd0, 16'd0});
        wr_reg(4'h0, 32'h1);
        repeat (65540) @(negedge clk);
        rd_reg(4'h8, v);
        check(v == 32'h5, "R9 roll-over cleared counters", v, 32'h5);
        base_busy = 8'h00;
    endtask

    task automatic t_halt();
        base_busy = 8'h02;
        wr_reg(4'h4, {16'd2, 16'd0});
        wr_reg(4'h0, 32'h1);
        repeat (20) @(negedge clk);
        wr_reg(4'h0, 32'h0);
        rd_reg(4'h0, v);
        check(v == 0, "R11 halted without done", v, 0);
        rd_reg(4'h8, v);
        check(v[15:0] == 0 && v[31:16] != 0, "R11 stage1 counted", v, 32'h0);
        repeat (20) @(negedge clk);
        rd_reg(4'h8, v2); rd_reg(4'h8, v2); rd_reg(4'h8, v2); rd_reg(4'h8, v2);
        check(v2 == v, "R11 counters hold", v2, v);
        base_busy = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_timing();
        t_winner();
        t_short();
        t_partial();
        t_zero();
        t_halt();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total_chk++; bad_chk++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end
endmodule